// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two binary32 floating-point operands and delivers a correctly rounded binary32 product. Each operand holds a sign bit, an 8-bit biased exponent (bias 127) and a 23-bit fraction. Operands with a zero exponent field are treated as zero, so subnormal inputs are flushed. The only rounding mode is round to nearest with ties going to the even neighbour.

The datapath is a three-stage pipeline. The first stage decodes both operands, picks out special encodings and forms the unbiased-corrected exponent sum. The second stage forms the 48-bit significand product. The third stage normalizes by at most one position, rounds, renormalizes on a rounding carry, clamps overflow and underflow, and registers the packed result along with three exception flags. A new operand pair may be presented on every cycle. Each result appears exactly three cycles after its operands, marked by an output strobe.

Top module: `fp32_mul_pipe`

## Requirements
- R1: For every result that is not NaN, the result sign bit (bit 31) equals the XOR of the two operand sign bits.
- R2: For two normal operands whose product needs no rounding increment and stays in range, the result exponent field is exp_a + exp_b - 127, plus 1 when the significand product is at least 2.0, and the fraction holds the 23 bits below the leading one.
- R3: Rounding is to nearest, ties to even. The bit just below the kept fraction is the guard bit, the next one is the round bit, and the OR of all lower product bits is the sticky bit. The kept fraction is incremented when guard is 1 and any of round, sticky or the fraction LSB is 1. A carry out of the fraction increments the exponent and clears the fraction.
- R4: If either operand is NaN (exponent field 255, fraction non-zero), the result is 0x7FC00000 and invalid (and no other flag) is raised.
- R5: Infinity (exponent field 255, fraction zero) times zero (exponent field 0) in either order gives 0x7FC00000 with invalid raised.
- R6: Infinity times a normal number or times infinity gives an infinity with the sign from R1 (exponent field 255, fraction 0), and no flag is raised.
- R7: Any operand whose exponent field is 0, whether zero or subnormal, times a normal number or zero gives a zero with the sign from R1, and no flag is raised.
- R8: When the final biased exponent after rounding is 255 or more, the result is a signed infinity and overflow is raised.
- R9: When the final biased exponent after rounding is 0 or less, the result is a signed zero and underflow is raised.
- R10: out_valid rises exactly three clock cycles after the cycle in which in_valid was sampled high. Back-to-back inputs produce back-to-back outputs in the same order.
- R11: While rst_n is low, out_valid, overflow, underflow and invalid are all 0.
- R12: At most one of overflow, underflow and invalid is set at a time, and all three are 0 whenever out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 32 | First operand, binary32 |
| op_b | input | 32 | Second operand, binary32 |
| out_valid | output | 1 | Result present this cycle |
| result | output | 32 | Rounded binary32 product |
| overflow | output | 1 | Product exceeded the largest finite magnitude |
| underflow | output | 1 | Product fell below the smallest normal magnitude |
| invalid | output | 1 | NaN operand, or infinity times zero |

## Verification
The bench goes after exact ties, with an even and an odd fraction LSB. A design that rounds ties away from zero, or that ignores sticky, gives a result one ULP off. It also targets products of 2.0 or more and rounding carries that ripple into the exponent; missing the normalization shift or the renormalization leaves an exponent that is wrong by one. Products placed exactly at exponent 255 and at exponent 0 are used to catch an off-by-one in the clamp, which would show up as a finite value where infinity or zero is required. Infinity times zero, NaN inputs and subnormal inputs are mixed into a back-to-back random stream, so a wrong NaN encoding, a flag left asserted or a pipeline slip shows up as a mismatch or a timing error.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;
  // Operand classification after decode (subnormals fold into zero).
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fpm_cls_e;

  // Kind of result decided before the significand product exists.
  typedef enum logic [1:0] {
    KIND_FIN  = 2'd0,
    KIND_ZERO = 2'd1,
    KIND_INF  = 2'd2,
    KIND_QNAN = 2'd3
  } fpm_kind_e;
endpackage

// File: rtl/fpm_unpack.sv
`timescale 1ns/1ps
module fpm_unpack
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1
) (
  input  logic [WORD_W-1:0] op,
  output fpm_cls_e          cls,
  output logic              sign,
  output logic [EXP_W-1:0]  exp_f,
  output logic [SIG_W-1:0]  sig
);
  logic [FRAC_W-1:0] frac;
  logic              exp_zero;
  logic              exp_ones;

  assign sign     = op[WORD_W-1];
  assign exp_f    = op[WORD_W-2 -: EXP_W];
  assign frac     = op[FRAC_W-1:0];
  assign exp_zero = ~|exp_f;
  assign exp_ones = &exp_f;

  // Hidden bit restored only for normal encodings.
  assign sig = {~exp_zero, frac};

  always_comb begin
    if (exp_ones) begin
      cls = (|frac) ? CLS_NAN : CLS_INF;
    end else if (exp_zero) begin
      cls = CLS_ZERO;
    end else begin
      cls = CLS_NORM;
    end
  end
endmodule

// File: rtl/fpm_round.sv
`timescale 1ns/1ps
module fpm_round
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W,
  localparam int EXT_W  = EXP_W + 2
) (
  input  logic                    sign,
  input  logic signed [EXT_W-1:0] exp_in,
  input  fpm_kind_e               kind,
  input  logic [PROD_W-1:0]       prod,
  output logic [WORD_W-1:0]       res,
  output logic                    ovf,
  output logic                    unf,
  output logic                    inv
);
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam logic signed [EXT_W-1:0] EMAX_S = EXT_W'(EMAX);
  localparam logic signed [EXT_W-1:0] ZERO_S = '0;
  localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam int LOW_W = PROD_W - FRAC_W - 3;

  logic                    hi;
  logic [PROD_W-1:0]       nrm;
  logic [FRAC_W-1:0]       frac_k;
  logic                    g_bit;
  logic                    r_bit;
  logic                    s_bit;
  logic                    rnd_up;
  logic [FRAC_W:0]         frac_sum;
  logic signed [EXT_W-1:0] exp_n;
  logic signed [EXT_W-1:0] exp_f;

  // One-position normalization: the leading one sits at PROD_W-1 or PROD_W-2.
  assign hi     = prod[PROD_W-1];
  assign nrm    = hi ? prod : (prod << 1);
  assign frac_k = nrm[PROD_W-2 -: FRAC_W];
  assign g_bit  = nrm[PROD_W-2-FRAC_W];
  assign r_bit  = nrm[PROD_W-3-FRAC_W];
  assign s_bit  = |nrm[LOW_W-1:0];
  assign exp_n  = exp_in + $signed({{(EXT_W-1){1'b0}}, hi});

  // Nearest-even increment and renormalization on carry-out.
  assign rnd_up   = g_bit & (r_bit | s_bit | frac_k[0]);
  assign frac_sum = {1'b0, frac_k} + {{FRAC_W{1'b0}}, rnd_up};
  assign exp_f    = exp_n + $signed({{(EXT_W-1){1'b0}}, frac_sum[FRAC_W]});

  always_comb begin
    res = {sign, {WORD_W-1{1'b0}}};
    ovf = 1'b0;
    unf = 1'b0;
    inv = 1'b0;
    unique case (kind)
      KIND_QNAN: begin
        res = QNAN;
        inv = 1'b1;
      end
      KIND_INF: begin
        res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end
      KIND_ZERO: begin
        res = {sign, {(WORD_W-1){1'b0}}};
      end
      default: begin
        if (exp_f >= EMAX_S) begin
          res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
          ovf = 1'b1;
        end else if (exp_f <= ZERO_S) begin
          res = {sign, {(WORD_W-1){1'b0}}};
          unf = 1'b1;
        end else begin
          res = {sign, exp_f[EXP_W-1:0], frac_sum[FRAC_W-1:0]};
        end
      end
    endcase
  end
endmodule

// File: rtl/fp32_mul_pipe.sv
`timescale 1ns/1ps
module fp32_mul_pipe
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              out_valid,
  output logic [WORD_W-1:0] result,
  output logic              overflow,
  output logic              underflow,
  output logic              invalid
);
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int EXT_W  = EXP_W + 2;
  localparam logic signed [EXT_W-1:0] BIAS_S = EXT_W'((1 << (EXP_W-1)) - 1);

  // ---------------- decode ----------------
  logic [WORD_W-1:0] ops [2];
  fpm_cls_e          cls [2];
  logic              sgn [2];
  logic [EXP_W-1:0]  exf [2];
  logic [SIG_W-1:0]  sig [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < 2; i++) begin : g_unp
    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
      .op    (ops[i]),
      .cls   (cls[i]),
      .sign  (sgn[i]),
      .exp_f (exf[i]),
      .sig   (sig[i])
    );
  end

  // ---------------- stage 1: classify, exponent sum ----------------
  logic                    s1_vld;
  logic                    s1_sign, s1_sign_d;
  logic signed [EXT_W-1:0] s1_exp,  s1_exp_d;
  fpm_kind_e               s1_kind, s1_kind_d;
  logic [SIG_W-1:0]        s1_siga, s1_sigb;

  always_comb begin
    logic any_nan, any_inf, any_zero;
    any_nan  = (cls[0] == CLS_NAN)  | (cls[1] == CLS_NAN);
    any_inf  = (cls[0] == CLS_INF)  | (cls[1] == CLS_INF);
    any_zero = (cls[0] == CLS_ZERO) | (cls[1] == CLS_ZERO);
    if (any_nan | (any_inf & any_zero)) begin
      s1_kind_d = KIND_QNAN;
    end else if (any_inf) begin
      s1_kind_d = KIND_INF;
    end else if (any_zero) begin
      s1_kind_d = KIND_ZERO;
    end else begin
      s1_kind_d = KIND_FIN;
    end
    s1_sign_d = sgn[0] ^ sgn[1];
    s1_exp_d  = $signed({2'b00, exf[0]}) + $signed({2'b00, exf[1]}) - BIAS_S;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_sign <= 1'b0;
      s1_exp  <= '0;
      s1_kind <= KIND_FIN;
      s1_siga <= '0;
      s1_sigb <= '0;
    end else begin
      s1_vld <= in_valid;
      if (in_valid) begin
        s1_sign <= s1_sign_d;
        s1_exp  <= s1_exp_d;
        s1_kind <= s1_kind_d;
        s1_siga <= sig[0];
        s1_sigb <= sig[1];
      end
    end
  end

  // ---------------- stage 2: significand product ----------------
  logic                    s2_vld;
  logic                    s2_sign;
  logic signed [EXT_W-1:0] s2_exp;
  fpm_kind_e               s2_kind;
  logic [PROD_W-1:0]       s2_prod, s2_prod_d;

  always_comb begin
    s2_prod_d = {{SIG_W{1'b0}}, s1_siga} * {{SIG_W{1'b0}}, s1_sigb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld  <= 1'b0;
      s2_sign <= 1'b0;
      s2_exp  <= '0;
      s2_kind <= KIND_FIN;
      s2_prod <= '0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_sign <= s1_sign;
        s2_exp  <= s1_exp;
        s2_kind <= s1_kind;
        s2_prod <= s2_prod_d;
      end
    end
  end

  // ---------------- stage 3: normalize, round, pack ----------------
  logic [WORD_W-1:0] rnd_res;
  logic              rnd_ovf, rnd_unf, rnd_inv;
  logic [2:0]        flags_d;

  fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
    .sign   (s2_sign),
    .exp_in (s2_exp),
    .kind   (s2_kind),
    .prod   (s2_prod),
    .res    (rnd_res),
    .ovf    (rnd_ovf),
    .unf    (rnd_unf),
    .inv    (rnd_inv)
  );

  // Flags are qualified by the strobe so they read 0 on idle cycles.
  always_comb begin
    flags_d = s2_vld ? {rnd_ovf, rnd_unf, rnd_inv} : 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= s2_vld;
      overflow  <= flags_d[2];
      underflow <= flags_d[1];
      invalid   <= flags_d[0];
      if (s2_vld) begin
        result <= rnd_res;
      end
    end
  end
endmodule

// File: rtl/fpm_mul_chk.sv
`timescale 1ns/1ps
module fpm_mul_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] op_a,
  input logic [WORD_W-1:0] op_b,
  input logic              out_valid,
  input logic [WORD_W-1:0] result,
  input logic              overflow,
  input logic              underflow,
  input logic              invalid
);
  localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [2:0] vld_sr;
  logic [2:0] nan_sr;
  logic [2:0] sgn_sr;
  logic       nan_in;

  assign nan_in = ((&op_a[WORD_W-2 -: EXP_W]) & (|op_a[FRAC_W-1:0])) |
                  ((&op_b[WORD_W-2 -: EXP_W]) & (|op_b[FRAC_W-1:0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_sr <= '0;
      nan_sr <= '0;
      sgn_sr <= '0;
    end else begin
      vld_sr <= {vld_sr[1:0], in_valid};
      nan_sr <= {nan_sr[1:0], in_valid & nan_in};
      sgn_sr <= {sgn_sr[1:0], op_a[WORD_W-1] ^ op_b[WORD_W-1]};
    end
  end

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vld_sr[2]);

  p_nan_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && nan_sr[2]) |-> (result == QNAN && invalid));

  p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !invalid) |-> (result[WORD_W-1] == sgn_sr[2]));

  p_onehot_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({overflow, underflow, invalid}));

  p_idle_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(overflow || underflow || invalid));

  p_ovf_inf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  p_unf_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (result[WORD_W-2:0] == '0));
endmodule

bind fp32_mul_pipe fpm_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .result    (result),
  .overflow  (overflow),
  .underflow (underflow),
  .invalid   (invalid)
);

// File: tb/fp32_mul_pipe_test.sv
`timescale 1ns/1ps
module fp32_mul_pipe_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic        out_valid;
  logic [31:0] result;
  logic        overflow, underflow, invalid;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;
  bit done     = 0;

  logic [63:0] ab_q  [$];
  int          due_q [$];

  fp32_mul_pipe uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result), .overflow(overflow),
    .underflow(underflow), .invalid(invalid)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference product computed from the requirements.
  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                output logic [31:0] r, output logic [2:0] fl,
                                output string tag);
    logic [7:0]  ea, eb;
    logic [22:0] fa, fb;
    logic        an, bn, ai, bi, az, bz, s, bumped;
    logic [47:0] p;
    logic [23:0] keep, lost;
    int          e;
    ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
    an = (ea == 8'hFF) && (fa != 0); bn = (eb == 8'hFF) && (fb != 0);
    ai = (ea == 8'hFF) && (fa == 0); bi = (eb == 8'hFF) && (fb == 0);
    az = (ea == 8'h00);              bz = (eb == 8'h00);
    s  = a[31] ^ b[31];
    fl = 3'b000; // {ovf, unf, inv}
    if (an || bn) begin
      r = 32'h7FC00000; fl = 3'b001; tag = "R4";
    end else if ((ai && bz) || (az && bi)) begin
      r = 32'h7FC00000; fl = 3'b001; tag = "R5";
    end else if (ai || bi) begin
      r = {s, 8'hFF, 23'd0}; tag = "R6";
    end else if (az || bz) begin
      r = {s, 31'd0}; tag = "R7";
    end else begin
      p = 48'({1'b1, fa}) * 48'({1'b1, fb});
      e = int'(ea) + int'(eb) - 127;
      if (p[47]) e = e + 1;
      else p = p << 1;
      keep = {1'b0, p[46:24]};
      lost = p[23:0];
      bumped = 1'b0;
      if (lost > 24'h800000 || (lost == 24'h800000 && p[24])) begin
        keep = keep + 24'd1;
        bumped = 1'b1;
      end
      if (keep[23]) e = e + 1;
      tag = bumped ? "R3" : "R2";
      if (e >= 255) begin
        r = {s, 8'hFF, 23'd0}; fl = 3'b100; tag = "R8";
      end else if (e <= 0) begin
        r = {s, 31'd0}; fl = 3'b010; tag = "R9";
      end else begin
        r = {s, e[7:0], keep[22:0]};
      end
    end
  endfunction

  function automatic logic [31:0] gen_op();
    logic [31:0] v;
    int k;
    v = $urandom();
    k = $urandom_range(0, 7);
    if (k < 4)       v[30:23] = 8'($urandom_range(100, 154));
    else if (k == 4) v[30:23] = 8'($urandom_range(1, 40));
    else if (k == 5) v[30:23] = 8'($urandom_range(215, 254));
    else if (k == 6) v[30:23] = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'hFF;
    if (k == 6 && $urandom_range(0, 1) == 0) v[22:0] = '0;
    if ($urandom_range(0, 15) == 0) v[22:0] = {23{1'b1}};
    return v;
  endfunction

  // Runs at a falling edge, after all registers have settled.
  task automatic service();
    bit          due;
    logic [63:0] ab;
    logic [31:0] er;
    logic [2:0]  ef;
    string       tag;
    due = (due_q.size() != 0) && (due_q[0] == cyc);
    chk(out_valid == due, "R10", "out_valid timing", 64'(out_valid), 64'(due));
    if (out_valid && due) begin
      ab = ab_q.pop_front();
      void'(due_q.pop_front());
      model(ab[63:32], ab[31:0], er, ef, tag);
      chk(result == er, tag, "result", 64'(result), 64'(er));
      chk({overflow, underflow, invalid} == ef, tag, "flags",
          64'({overflow, underflow, invalid}), 64'(ef));
      chk($countones({overflow, underflow, invalid}) <= 1, "R12", "flag exclusivity",
          64'({overflow, underflow, invalid}), 64'(ef));
      if (!ef[0])
        chk(result[31] == (ab[63] ^ ab[31]), "R1", "sign", 64'(result[31]),
            64'(ab[63] ^ ab[31]));
    end else if (!out_valid) begin
      chk({overflow, underflow, invalid} == 3'b000, "R12", "idle flags",
          64'({overflow, underflow, invalid}), 64'(0));
    end
  endtask

  task automatic issue(input bit v, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    service();
    in_valid = v;
    op_a = a;
    op_b = b;
    if (v) begin
      ab_q.push_back({a, b});
      due_q.push_back(cyc + 3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0, "R11", "out_valid in reset", 64'(out_valid), 64'(0));
    chk({overflow, underflow, invalid} == 3'b000, "R11", "flags in reset",
        64'({overflow, underflow, invalid}), 64'(0));
    in_valid = 1'b1; op_a = 32'h7FC00000; op_b = 32'h3F800000;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", "in_valid ignored in reset", 64'(out_valid), 64'(0));
    in_valid = 1'b0;
    rst_n = 1'b1;

    // Directed corners
    issue(1, 32'h3F800000, 32'h3F800000); // R2 1.0*1.0
    issue(1, 32'h3FC00000, 32'h3FC00000); // R2 product >= 2
    issue(1, 32'h3F000000, 32'hBEE00000); // R1 R2 negative result
    issue(1, 32'h3F800001, 32'h3FC00000); // R3 tie, odd LSB rounds up
    issue(1, 32'h3F800003, 32'h3FC00000); // R3 tie, even LSB stays
    issue(1, 32'h3FFFFFFF, 32'h3F800001); // R3 carry region
    issue(1, 32'h3FFFFFFF, 32'h3FFFFFFF); // R3
    issue(1, 32'h7F000000, 32'h40000000); // R8 exactly 255
    issue(1, 32'hFF7FFFFF, 32'h3FC00000); // R8 negative
    issue(1, 32'h7F7FFFFF, 32'h3F800000); // R2 max finite
    issue(1, 32'h00800000, 32'h3F000000); // R9 exactly 0
    issue(1, 32'h80800000, 32'h00800000); // R9 deep
    issue(1, 32'h00800000, 32'h3F800000); // R2 min normal
    issue(1, 32'h7F800000, 32'h00000000); // R5
    issue(1, 32'h80000000, 32'hFF800000); // R5 reversed
    issue(1, 32'h7F800001, 32'h3F800000); // R4 signalling-style NaN
    issue(1, 32'h40A00000, 32'hFFC00000); // R4
    issue(1, 32'h7F800000, 32'hC0000000); // R6 -inf
    issue(1, 32'hFF800000, 32'hFF800000); // R6 +inf
    issue(1, 32'h00000000, 32'hC0A00000); // R7 -0
    issue(1, 32'h00000001, 32'h40000000); // R7 subnormal flushed
    issue(0, 32'h0, 32'h0);
    issue(0, 32'h0, 32'h0);

    // Random stream, mostly back-to-back
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 9) == 0) issue(0, gen_op(), gen_op());
      else issue(1, gen_op(), gen_op());
    end

    for (int n = 0; n < 6; n++) issue(0, 32'h0, 32'h0);
    chk(due_q.size() == 0, "R10", "all results delivered", 64'(due_q.size()), 64'(0));
    done = 1;
    report();
    $finish;
  end
endmodule